// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock waveform for an I2C master engine. It works in two stages. A prescaler first divides the system clock down to a slow reference tick of roughly 10 MHz. The prescale value is chosen as the system clock in MHz plus 5, divided by 10. A phase sequencer then counts reference ticks to build the low half and the high half of each SCL period. The two half lengths are set independently from the two bytes of one divider word. For a target rate in kHz, each half count is ((10000 / rate) + 1) / 2.

The generator pulls SCL low during the low half and releases it during the high half. During the high half it counts only those reference ticks on which the synchronized SCL line actually reads high. A slave that stretches the clock by holding SCL low therefore lengthens the high half and does not shorten it. Single-cycle strobes at the middle of each half tell the engine when to change SDA and when to sample it. The engine controls the generator with start and stop pulses, and the generator runs only while the enable input is set.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, and at any time the generator is idle, SCL is released (`scl_pull` = 0), `busy` = 0, and neither strobe is asserted.
- R2: The low half count sits in `divider[7:0]`. Once running, every low half after the first lasts L × P system cycles, where L is that count and P is `prescale`. A prescale of 0 behaves as 1.
- R3: The high half count sits in `divider[15:8]`. If the SCL line follows the released pull within one cycle and P ≥ 3, every high half lasts H × P system cycles.
- R4: A low or high count of 0 behaves as a count of 1.
- R5: The SCL input passes through a two-stage synchronizer. A reference tick advances the high-half count only if the synchronized line is high on that tick. If the line is held low for S cycles after release, the high half lasts (ceil((S+3)/P) + H − 1) × P cycles.
- R6: `mid_low_stb` is a one-cycle pulse. It follows the start of the low half by ceil(L/2) × P cycles, and it is only ever asserted right after a cycle in which SCL was pulled.
- R7: `mid_high_stb` is a one-cycle pulse. Without stretching, it follows the release of SCL by ceil(H/2) × P cycles. The two strobes are never asserted together.
- R8: A `start` pulse while enabled and idle pulls SCL low and sets `busy` on the next clock edge. The generator does not keep a start pulse that was ignored.
- R9: A `stop` pulse while running is held pending and takes effect at the next end of a low half. At that edge SCL is released and `busy` falls, and no further toggling follows.
- R10: While `enable` is 0, the generator is idle with SCL released from the next edge on, and `start` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Main enable; when clear the generator is held idle |
| prescale | input | PRE_W (7) | System-clock cycles per reference tick (0 acts as 1) |
| divider | input | 2*CNT_W (16) | High-half ticks in upper byte, low-half ticks in lower byte |
| start | input | 1 | Pulse: begin toggling SCL from idle |
| stop | input | 1 | Pulse: finish at the end of the next low half |
| scl_in | input | 1 | Sensed SCL line level (asynchronous) |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release |
| busy | output | 1 | Generator is running |
| mid_low_stb | output | 1 | One-cycle strobe at the middle of the low half |
| mid_high_stb | output | 1 | One-cycle strobe at the middle of the high half |

## Verification
A prescaler counter stuck or off by one moves every half-period by a whole number of system cycles. The error shows at the first fully measured half after start, within a few reference ticks. A high-phase counter that ignores the synchronized line shows up in the first stretched high half, which then ends early by a predictable number of cycles. A stop flag that is lost or latched too early shows up within one low half, either as continued toggling or as a shortened final low phase. A mid-point compare that is wrong moves the strobe away from ceil(n/2) ticks in the very first measured half.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_ref_prescaler.sv
module scl_ref_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] ratio,
  output logic             ref_tick
);

  logic [PRE_W-1:0] eff_ratio;
  logic [PRE_W-1:0] div_cnt;

  // a ratio of zero is treated as one
  assign eff_ratio = (ratio == '0) ? PRE_W'(1) : ratio;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt  <= '0;
      ref_tick <= 1'b0;
    end else if (div_cnt == eff_ratio - PRE_W'(1)) begin
      div_cnt  <= '0;
      ref_tick <= 1'b1;
    end else begin
      div_cnt  <= div_cnt + PRE_W'(1);
      ref_tick <= 1'b0;
    end
  end

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_async,
  output logic line_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= line_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign line_sync = chain[STAGES-1];

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic             stop,
  input  logic             ref_tick,
  input  logic             line_high,
  input  logic [CNT_W-1:0] hi_ticks,
  input  logic [CNT_W-1:0] lo_ticks,
  output logic             pull_low,
  output logic             running,
  output logic             mid_low,
  output logic             mid_high
);

  scl_phase_e       phase;
  logic [CNT_W-1:0] tick_cnt;
  logic             stop_pend;
  logic [CNT_W-1:0] eff_lo;
  logic [CNT_W-1:0] eff_hi;
  logic [CNT_W-1:0] last_lo;
  logic [CNT_W-1:0] last_hi;
  logic [CNT_W-1:0] half_lo;
  logic [CNT_W-1:0] half_hi;

  always_comb begin
    eff_lo  = (lo_ticks == '0) ? CNT_W'(1) : lo_ticks;
    eff_hi  = (hi_ticks == '0) ? CNT_W'(1) : hi_ticks;
    last_lo = eff_lo - CNT_W'(1);
    last_hi = eff_hi - CNT_W'(1);
    half_lo = last_lo >> 1;
    half_hi = last_hi >> 1;
  end

  assign running = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      phase     <= PH_IDLE;
      tick_cnt  <= '0;
      stop_pend <= 1'b0;
      pull_low  <= 1'b0;
      mid_low   <= 1'b0;
      mid_high  <= 1'b0;
    end else begin
      mid_low  <= 1'b0;
      mid_high <= 1'b0;
      if (stop && phase != PH_IDLE) stop_pend <= 1'b1;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase    <= PH_LOW;
            pull_low <= 1'b1;
            tick_cnt <= '0;
          end
        end
        PH_LOW: begin
          if (ref_tick) begin
            if (tick_cnt == half_lo) mid_low <= 1'b1;
            if (tick_cnt == last_lo) begin
              tick_cnt <= '0;
              pull_low <= 1'b0;
              if (stop_pend || stop) begin
                phase     <= PH_IDLE;
                stop_pend <= 1'b0;
              end else begin
                phase <= PH_HIGH;
              end
            end else begin
              tick_cnt <= tick_cnt + CNT_W'(1);
            end
          end
        end
        PH_HIGH: begin
          // ticks only count once the line is seen high (stretch support)
          if (ref_tick && line_high) begin
            if (tick_cnt == half_hi) mid_high <= 1'b1;
            if (tick_cnt == last_hi) begin
              tick_cnt <= '0;
              pull_low <= 1'b1;
              phase    <= PH_LOW;
            end else begin
              tick_cnt <= tick_cnt + CNT_W'(1);
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int PRE_W     = 7,
  parameter int CNT_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [PRE_W-1:0]   prescale,
  input  logic [2*CNT_W-1:0] divider,
  input  logic               start,
  input  logic               stop,
  input  logic               scl_in,
  output logic               scl_pull,
  output logic               busy,
  output logic               mid_low_stb,
  output logic               mid_high_stb
);

  localparam int DIV_W = 2 * CNT_W;

  logic             ref_tick;
  logic             line_high;
  logic [CNT_W-1:0] hi_ticks;
  logic [CNT_W-1:0] lo_ticks;

  assign hi_ticks = divider[DIV_W-1:CNT_W];
  assign lo_ticks = divider[CNT_W-1:0];

  scl_ref_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (enable && busy),
    .ratio    (prescale),
    .ref_tick (ref_tick)
  );

  scl_line_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .line_async (scl_in),
    .line_sync  (line_high)
  );

  scl_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .start     (start),
    .stop      (stop),
    .ref_tick  (ref_tick),
    .line_high (line_high),
    .hi_ticks  (hi_ticks),
    .lo_ticks  (lo_ticks),
    .pull_low  (scl_pull),
    .running   (busy),
    .mid_low   (mid_low_stb),
    .mid_high  (mid_high_stb)
  );

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic start,
  input logic scl_pull,
  input logic busy,
  input logic mid_low_stb,
  input logic mid_high_stb
);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !scl_pull);

  // R6
  mid_low_in_low_chk: assert property (@(posedge clk) disable iff (rst)
    mid_low_stb |-> $past(scl_pull));

  // R7
  mid_high_in_high_chk: assert property (@(posedge clk) disable iff (rst)
    mid_high_stb |-> !$past(scl_pull));

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mid_low_stb, mid_high_stb}));

  // R8
  start_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (start && enable && !busy) |=> (busy && scl_pull));

  // R9
  stop_after_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(scl_pull) || !$past(enable)));

  // R10
  disable_idles_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !scl_pull));

endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .start        (start),
  .scl_pull     (scl_pull),
  .busy         (busy),
  .mid_low_stb  (mid_low_stb),
  .mid_high_stb (mid_high_stb)
);

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

  localparam int LIMIT = 4000;

  logic        clk = 1'b0;
  logic        rst, enable, start, stop, hold;
  logic [6:0]  prescale;
  logic [15:0] divider;
  logic        scl_pull, busy, mid_low_stb, mid_high_stb;
  logic        scl_line;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  // open-drain line: low when pulled by the generator or held by a stretching slave
  assign scl_line = !scl_pull && !hold;

  scl_clock_gen uut (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .prescale     (prescale),
    .divider      (divider),
    .start        (start),
    .stop         (stop),
    .scl_in       (scl_line),
    .scl_pull     (scl_pull),
    .busy         (busy),
    .mid_low_stb  (mid_low_stb),
    .mid_high_stb (mid_high_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int ceil_half(input int v);
    return (v + 1) / 2;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    step();
    stop = 1'b0;
  endtask

  task automatic restart(input int p, input int h, input int l);
    enable = 1'b0;
    step();
    prescale = 7'(p);
    divider  = {8'(h), 8'(l)};
    enable   = 1'b1;
    step();
    pulse_start();
  endtask

  task automatic wait_pull(input logic v);
    int n = 0;
    while (scl_pull !== v && n < LIMIT) begin
      step();
      n++;
    end
    if (n >= LIMIT) check(1'b0, "R8 wait timeout", n, 0);
  endtask

  // measure from a fresh phase edge to the next transition, noting the strobe
  task automatic measure(input logic cur, input bit low_ph, output int len, output int mid_at);
    len    = 0;
    mid_at = -1;
    do begin
      step();
      len++;
      if ((low_ph ? mid_low_stb : mid_high_stb) && mid_at < 0) mid_at = len;
    end while (scl_pull === cur && len < LIMIT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int len, mid, strays;
    int lv[4] = '{0, 1, 2, 5};
    int hv[4] = '{0, 1, 3, 4};
    int sv[4] = '{1, 4, 7, 10};

    rst = 1'b1; enable = 1'b0; start = 1'b0; stop = 1'b0; hold = 1'b0;
    prescale = 7'd3; divider = 16'h0202;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state
    check(scl_pull == 1'b0 && busy == 1'b0, "R1 reset", {busy, scl_pull}, 0);
    enable = 1'b1;
    strays = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (scl_pull || busy || mid_low_stb || mid_high_stb) strays++;
    end
    check(strays == 0, "R1 idle without start", strays, 0);

    // R2 R3 R4 R6 R7: sweep prescale and both half counts
    for (int p = 3; p <= 5; p++) begin
      for (int li = 0; li < 4; li++) begin
        for (int hi = 0; hi < 4; hi++) begin
          restart(p, hv[hi], lv[li]);
          wait_pull(1'b0);
          measure(1'b0, 1'b0, len, mid);
          check(len == eff(hv[hi]) * p, "R3 R4 high length", len, eff(hv[hi]) * p);
          check(mid == ceil_half(eff(hv[hi])) * p, "R7 mid high", mid, ceil_half(eff(hv[hi])) * p);
          measure(1'b1, 1'b1, len, mid);
          check(len == eff(lv[li]) * p, "R2 R4 low length", len, eff(lv[li]) * p);
          check(mid == ceil_half(eff(lv[li])) * p, "R6 mid low", mid, ceil_half(eff(lv[li])) * p);
        end
      end
    end

    // R2: small prescale values, 0 acting as 1
    for (int p = 0; p <= 2; p++) begin
      restart(p, 2, 3);
      wait_pull(1'b0);
      wait_pull(1'b1);
      measure(1'b1, 1'b1, len, mid);
      check(len == 3 * eff(p), "R2 low with small prescale", len, 3 * eff(p));
    end

    // R5: clock stretching
    for (int si = 0; si < 4; si++) begin
      int s = sv[si];
      int k0 = (s + 3 + 2) / 3;
      restart(3, 2, 2);
      hold = 1'b1;
      wait_pull(1'b0);
      len = 0;
      do begin
        step();
        len++;
        if (len == s) hold = 1'b0;
      end while (scl_pull === 1'b0 && len < LIMIT);
      hold = 1'b0;
      check(len == (k0 + 1) * 3, "R5 stretched high length", len, (k0 + 1) * 3);
    end

    // R9: stop issued in the high half
    restart(3, 2, 3);
    wait_pull(1'b0);
    pulse_stop();
    wait_pull(1'b1);
    measure(1'b1, 1'b1, len, mid);
    check(len == 9, "R9 final low length", len, 9);
    check(busy == 1'b0, "R9 busy falls with release", busy, 0);
    strays = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (scl_pull || busy || mid_low_stb || mid_high_stb) strays++;
    end
    check(strays == 0, "R9 no toggling after stop", strays, 0);

    // R9: stop issued in the low half
    restart(3, 2, 2);
    wait_pull(1'b0);
    wait_pull(1'b1);
    pulse_stop();
    wait_pull(1'b0);
    check(busy == 1'b0, "R9 stop in low half", busy, 0);

    // R10: enable drop while running, and start while disabled
    restart(3, 2, 2);
    wait_pull(1'b0);
    enable = 1'b0;
    step();
    check(scl_pull == 1'b0 && busy == 1'b0, "R10 disable idles", {busy, scl_pull}, 0);
    pulse_start();
    check(busy == 1'b0, "R10 start ignored while disabled", busy, 0);
    enable = 1'b1;
    step();
    step();
    check(busy == 1'b0 && scl_pull == 1'b0, "R8 ignored start not kept", {busy, scl_pull}, 0);

    // R8: start response on the next edge
    pulse_start();
    check(busy == 1'b1 && scl_pull == 1'b1, "R8 start pulls low", {busy, scl_pull}, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule